// File: doc/BRIEF.md
# In-Group Store-Load Overlap Detector

This block keeps a small table of the memory footprints written by stores issued in the current dispatch group. It reports, combinationally, whether a load being considered for the same group would touch bytes that one of those stores writes. An issue stage uses that bit to hold the load back or to pad the group.

A footprint is symbolic. It is a base tag that names the base register or value, a signed byte offset from that base, and a byte size. No real address is formed. Two footprints can only collide when their base tags are equal. When they are, the offset intervals are compared.

A store strobe appends an entry while the table has room. Any store after the table is full is silently lost for the rest of the group. A group-end strobe empties the table.

Top module: `grp_overlap_det`

## Requirements
- R1: The table keeps up to DEPTH (default 4) stores in emit order, and a load is compared against every valid entry. A hit on any one of them raises `ld_conflict_o`.
- R2: A store strobed while DEPTH entries are already valid is discarded. A later load that matches only that discarded store reports no conflict.
- R3: A load whose base tag and offset both equal those of a valid entry is a conflict, whatever the two sizes are (including size 0).
- R4: With equal tags and a store offset strictly below the load offset, the load conflicts exactly when store offset + store size is greater than the load offset.
- R5: With equal tags and a store offset at or above the load offset, the load conflicts exactly when load offset + load size is greater than the store offset.
- R6: A load whose base tag differs from an entry's tag never conflicts with that entry, whatever the offsets and sizes.
- R7: `ld_conflict_o` is 0 whenever `ld_query_i` is 0 and whenever no entry is valid.
- R8: A `grp_end_i` pulse invalidates every entry from the next cycle on.
- R9: When `st_emit_i` and `grp_end_i` are high in the same cycle, the clear wins and the store is not recorded.
- R10: Reset (`rst_n` low, active low, asynchronous) leaves the table empty.
- R11: Offsets are 16-bit two's complement values and sizes are 5-bit unsigned values. The interval sums are formed at a wider width, so they never wrap. For example, a store at 32760 of size 10 overlaps a load at 32767.
- R12: `ld_conflict_o` depends combinationally on the load inputs. A store strobed in a cycle is recorded at that cycle's rising edge and is visible to loads from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| grp_end_i | input | 1 | Dispatch group closes; clear the table |
| st_emit_i | input | 1 | A store is emitted this cycle |
| st_tag_i | input | TAG_W | Base tag of the emitted store |
| st_ofs_i | input | OFS_W | Signed byte offset of the emitted store |
| st_size_i | input | SIZE_W | Byte size of the emitted store |
| ld_query_i | input | 1 | A load is being checked this cycle |
| ld_tag_i | input | TAG_W | Base tag of the queried load |
| ld_ofs_i | input | OFS_W | Signed byte offset of the queried load |
| ld_size_i | input | SIZE_W | Byte size of the queried load |
| ld_conflict_o | output | 1 | Load overlaps a recorded store |

## Verification
The assertions assume that the strobes are never X after reset and that a store strobe lasts for exactly the cycles in which stores are emitted. No other ordering between the strobes is assumed, because the clear-wins rule settles overlaps.

The bench drives every input on the falling edge and holds it steady across the following rising edge. It reads the combinational conflict bit just after the falling edge. A store emitted in a cycle is therefore only checked against loads from the next cycle on, except in the one directed test that checks that timing.

The tag, offset and size stimuli stay inside the declared widths. They include the two's-complement extremes, so that no input is ever out of range.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
    localparam int OVL_TAG_W  = 8;
    localparam int OVL_OFS_W  = 16;
    localparam int OVL_SIZE_W = 5;
    localparam int OVL_DEPTH  = 4;

    typedef enum logic [1:0] {
        TBL_HOLD  = 2'd0,
        TBL_PUSH  = 2'd1,
        TBL_CLEAR = 2'd2
    } tbl_act_e;
endpackage

// File: rtl/ovl_range_cmp.sv
module ovl_range_cmp #(
    parameter int TAG_W  = 8,
    parameter int OFS_W  = 16,
    parameter int SIZE_W = 5
) (
    input  logic              en_i,
    input  logic [TAG_W-1:0]  s_tag_i,
    input  logic [OFS_W-1:0]  s_ofs_i,
    input  logic [SIZE_W-1:0] s_size_i,
    input  logic [TAG_W-1:0]  l_tag_i,
    input  logic [OFS_W-1:0]  l_ofs_i,
    input  logic [SIZE_W-1:0] l_size_i,
    output logic              hit_o
);
    localparam int BASE_W = (OFS_W > SIZE_W) ? OFS_W : SIZE_W;
    localparam int EXT_W  = BASE_W + 2;

    logic signed [EXT_W-1:0] s_lo, l_lo, s_hi, l_hi;
    logic                    tag_eq, ofs_eq, s_below;

    always_comb begin
        // widen so interval end points never wrap (R11)
        s_lo    = {{(EXT_W-OFS_W){s_ofs_i[OFS_W-1]}}, s_ofs_i};
        l_lo    = {{(EXT_W-OFS_W){l_ofs_i[OFS_W-1]}}, l_ofs_i};
        s_hi    = s_lo + {{(EXT_W-SIZE_W){1'b0}}, s_size_i};
        l_hi    = l_lo + {{(EXT_W-SIZE_W){1'b0}}, l_size_i};
        tag_eq  = (s_tag_i == l_tag_i);
        ofs_eq  = (s_lo == l_lo);
        s_below = (s_lo < l_lo);
        hit_o   = 1'b0;
        if (en_i && tag_eq) begin
            if (ofs_eq)       hit_o = 1'b1;        // R3
            else if (s_below) hit_o = (s_hi > l_lo); // R4
            else              hit_o = (l_hi > s_lo); // R5
        end
    end
endmodule

// File: rtl/ovl_store_table.sv
module ovl_store_table
    import ovl_pkg::*;
#(
    parameter int TAG_W  = 8,
    parameter int OFS_W  = 16,
    parameter int SIZE_W = 5,
    parameter int DEPTH  = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         grp_end_i,
    input  logic                         st_emit_i,
    input  logic [TAG_W-1:0]             st_tag_i,
    input  logic [OFS_W-1:0]             st_ofs_i,
    input  logic [SIZE_W-1:0]            st_size_i,
    output logic [DEPTH-1:0]             vld_o,
    output logic [DEPTH-1:0][TAG_W-1:0]  tag_o,
    output logic [DEPTH-1:0][OFS_W-1:0]  ofs_o,
    output logic [DEPTH-1:0][SIZE_W-1:0] size_o
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [CNT_W-1:0]             cnt;
        logic [DEPTH-1:0]             vld;
        logic [DEPTH-1:0][TAG_W-1:0]  tag;
        logic [DEPTH-1:0][OFS_W-1:0]  ofs;
        logic [DEPTH-1:0][SIZE_W-1:0] size;
    } tbl_t;

    tbl_t     tbl_d, tbl_q;
    tbl_act_e act;
    logic     full;

    always_comb begin
        full  = (tbl_q.cnt >= CNT_W'(DEPTH));
        tbl_d = tbl_q;
        if (grp_end_i)                act = TBL_CLEAR;   // R9 clear wins
        else if (st_emit_i && !full)  act = TBL_PUSH;
        else                          act = TBL_HOLD;    // R2 drop when full
        case (act)
            TBL_CLEAR: begin
                tbl_d.cnt = '0;
                tbl_d.vld = '0;
            end
            TBL_PUSH: begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (tbl_q.cnt == CNT_W'(i)) begin
                        tbl_d.vld[i]  = 1'b1;
                        tbl_d.tag[i]  = st_tag_i;
                        tbl_d.ofs[i]  = st_ofs_i;
                        tbl_d.size[i] = st_size_i;
                    end
                end
                tbl_d.cnt = tbl_q.cnt + CNT_W'(1);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tbl_q <= '0;   // R10
        else        tbl_q <= tbl_d;
    end

    assign vld_o  = tbl_q.vld;
    assign tag_o  = tbl_q.tag;
    assign ofs_o  = tbl_q.ofs;
    assign size_o = tbl_q.size;

    assert_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_q.cnt <= CNT_W'(DEPTH));
    assert_vld_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(tbl_q.vld) == int'(tbl_q.cnt));
    assert_full_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (full && st_emit_i && !grp_end_i) |=> $stable(tbl_q));
    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        grp_end_i |=> (tbl_q.vld == '0));
    assert_push_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (st_emit_i && !grp_end_i && !full) |=> (tbl_q.cnt == $past(tbl_q.cnt) + CNT_W'(1)));
endmodule

// File: rtl/grp_overlap_det.sv
module grp_overlap_det
    import ovl_pkg::*;
#(
    parameter int TAG_W  = OVL_TAG_W,
    parameter int OFS_W  = OVL_OFS_W,
    parameter int SIZE_W = OVL_SIZE_W,
    parameter int DEPTH  = OVL_DEPTH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              grp_end_i,
    input  logic              st_emit_i,
    input  logic [TAG_W-1:0]  st_tag_i,
    input  logic [OFS_W-1:0]  st_ofs_i,
    input  logic [SIZE_W-1:0] st_size_i,
    input  logic              ld_query_i,
    input  logic [TAG_W-1:0]  ld_tag_i,
    input  logic [OFS_W-1:0]  ld_ofs_i,
    input  logic [SIZE_W-1:0] ld_size_i,
    output logic              ld_conflict_o
);
    logic [DEPTH-1:0]             vld;
    logic [DEPTH-1:0][TAG_W-1:0]  tag;
    logic [DEPTH-1:0][OFS_W-1:0]  ofs;
    logic [DEPTH-1:0][SIZE_W-1:0] size;
    logic [DEPTH-1:0]             hit;

    ovl_store_table #(
        .TAG_W(TAG_W), .OFS_W(OFS_W), .SIZE_W(SIZE_W), .DEPTH(DEPTH)
    ) u_table (
        .clk(clk), .rst_n(rst_n),
        .grp_end_i(grp_end_i), .st_emit_i(st_emit_i),
        .st_tag_i(st_tag_i), .st_ofs_i(st_ofs_i), .st_size_i(st_size_i),
        .vld_o(vld), .tag_o(tag), .ofs_o(ofs), .size_o(size)
    );

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        ovl_range_cmp #(
            .TAG_W(TAG_W), .OFS_W(OFS_W), .SIZE_W(SIZE_W)
        ) u_cmp (
            .en_i(vld[g]),
            .s_tag_i(tag[g]), .s_ofs_i(ofs[g]), .s_size_i(size[g]),
            .l_tag_i(ld_tag_i), .l_ofs_i(ld_ofs_i), .l_size_i(ld_size_i),
            .hit_o(hit[g])
        );

        assert_tag_miss_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (tag[g] != ld_tag_i) |-> !hit[g]);
        assert_invalid_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !vld[g] |-> !hit[g]);
    end

    assign ld_conflict_o = ld_query_i && (|hit);

    assert_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_query_i || (vld == '0)) |-> !ld_conflict_o);
    assert_exact_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_query_i && vld[0] && tag[0] == ld_tag_i && ofs[0] == ld_ofs_i) |-> ld_conflict_o);
endmodule

// File: tb/grp_overlap_det_tb.sv
module grp_overlap_det_tb;
    localparam int TW = 8;
    localparam int OW = 16;
    localparam int SW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          grp_end = 1'b0;
    logic          st_emit = 1'b0;
    logic [TW-1:0] st_tag = '0;
    logic [OW-1:0] st_ofs = '0;
    logic [SW-1:0] st_size = '0;
    logic          ld_query = 1'b0;
    logic [TW-1:0] ld_tag = '0;
    logic [OW-1:0] ld_ofs = '0;
    logic [SW-1:0] ld_size = '0;
    logic          conflict;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    grp_overlap_det u_dut (
        .clk(clk), .rst_n(rst_n), .grp_end_i(grp_end),
        .st_emit_i(st_emit), .st_tag_i(st_tag), .st_ofs_i(st_ofs), .st_size_i(st_size),
        .ld_query_i(ld_query), .ld_tag_i(ld_tag), .ld_ofs_i(ld_ofs), .ld_size_i(ld_size),
        .ld_conflict_o(conflict)
    );

    typedef struct packed {
        logic [TW-1:0] s_tag;
        logic [OW-1:0] s_ofs;
        logic [SW-1:0] s_size;
        logic [TW-1:0] l_tag;
        logic [OW-1:0] l_ofs;
        logic [SW-1:0] l_size;
        logic          exp;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{8'd1, 16'd0,     5'd4,  8'd1, 16'd0,     5'd4,  1'b1}, // R3 exact
        '{8'd3, 16'd0,     5'd4,  8'd3, 16'd4,     5'd4,  1'b0}, // R4 touch, no overlap
        '{8'd3, 16'd0,     5'd5,  8'd3, 16'd4,     5'd4,  1'b1}, // R4 overlap by one
        '{8'd3, 16'd8,     5'd4,  8'd3, 16'd4,     5'd4,  1'b0}, // R5 touch
        '{8'd3, 16'd8,     5'd4,  8'd3, 16'd4,     5'd5,  1'b1}, // R5 overlap by one
        '{8'd5, 16'd12,    5'd8,  8'd6, 16'd12,    5'd8,  1'b0}, // R6 tags differ
        '{8'd7, 16'hFFFC,  5'd4,  8'd7, 16'hFFFF,  5'd1,  1'b1}, // R4 negative offsets
        '{8'd7, 16'hFFFC,  5'd3,  8'd7, 16'hFFFF,  5'd1,  1'b0}, // R4 negative, touch
        '{8'd9, 16'd32760, 5'd10, 8'd9, 16'd32767, 5'd1,  1'b1}, // R11 no wrap
        '{8'd9, 16'd32760, 5'd31, 8'd9, 16'h8000,  5'd31, 1'b0}, // R11 extremes apart
        '{8'd2, 16'd20,    5'd0,  8'd2, 16'd20,    5'd0,  1'b1}, // R3 zero sizes
        '{8'd2, 16'd5,     5'd0,  8'd2, 16'd3,     5'd2,  1'b0}  // R5 touch at store
    };

    task automatic check(input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b", what, act, exp);
        end
    endtask

    task automatic clear_grp();
        @(negedge clk); grp_end = 1'b1;
        @(negedge clk); grp_end = 1'b0;
    endtask

    task automatic store(input logic [TW-1:0] t, input logic [OW-1:0] o, input logic [SW-1:0] s);
        @(negedge clk);
        st_emit = 1'b1; st_tag = t; st_ofs = o; st_size = s;
        @(negedge clk); st_emit = 1'b0;
    endtask

    task automatic query(input logic [TW-1:0] t, input logic [OW-1:0] o,
                         input logic [SW-1:0] s, input logic exp, input string what);
        ld_query = 1'b1; ld_tag = t; ld_ofs = o; ld_size = s;
        #1;
        check(conflict, exp, what);
        ld_query = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state: empty table
        ld_query = 1'b1; ld_tag = 8'd0; ld_ofs = 16'd0; ld_size = 5'd4; #1;
        check(conflict, 1'b0, "R10 reset empty");
        ld_query = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        query(8'd0, 16'd0, 5'd4, 1'b0, "R7 no valid entry");

        for (int i = 0; i < NV; i++) begin
            clear_grp();
            store(VECS[i].s_tag, VECS[i].s_ofs, VECS[i].s_size);
            query(VECS[i].l_tag, VECS[i].l_ofs, VECS[i].l_size, VECS[i].exp,
                  $sformatf("vector %0d (R3/R4/R5/R6/R11)", i));
        end

        // R1: four entries, hit on last and middle
        clear_grp();
        store(8'd1, 16'd0, 5'd4); store(8'd2, 16'd0, 5'd4);
        store(8'd3, 16'd0, 5'd4); store(8'd4, 16'd100, 5'd4);
        query(8'd4, 16'd102, 5'd1, 1'b1, "R1 hit fourth entry");
        query(8'd2, 16'd3,   5'd1, 1'b1, "R1 hit second entry");
        // R7: matching load but query low
        ld_query = 1'b0; ld_tag = 8'd2; ld_ofs = 16'd0; ld_size = 5'd4; #1;
        check(conflict, 1'b0, "R7 query idle");
        // R2: fifth store dropped
        store(8'd5, 16'd0, 5'd4);
        query(8'd5, 16'd0, 5'd4, 1'b0, "R2 fifth store dropped");
        query(8'd1, 16'd0, 5'd4, 1'b1, "R2 earlier entries kept");
        // R8: clear
        clear_grp();
        query(8'd1, 16'd0, 5'd4, 1'b0, "R8 cleared");
        // R9: clear wins
        @(negedge clk);
        st_emit = 1'b1; grp_end = 1'b1; st_tag = 8'd6; st_ofs = 16'd8; st_size = 5'd4;
        @(negedge clk); st_emit = 1'b0; grp_end = 1'b0;
        query(8'd6, 16'd8, 5'd4, 1'b0, "R9 clear wins");
        // R12: store visible only after its edge
        @(negedge clk);
        st_emit = 1'b1; st_tag = 8'd7; st_ofs = 16'd40; st_size = 5'd2;
        ld_query = 1'b1; ld_tag = 8'd7; ld_ofs = 16'd40; ld_size = 5'd2; #1;
        check(conflict, 1'b0, "R12 same-cycle store not seen");
        @(negedge clk); st_emit = 1'b0;
        query(8'd7, 16'd41, 5'd1, 1'b1, "R12 store seen next cycle");
        // R10: reset mid-group
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        query(8'd7, 16'd40, 5'd2, 1'b0, "R10 reset mid-group");
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired: actual hung expected done");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule